// File: doc/BRIEF.md
# Cascadable Priority Interrupt Controller

This block gathers eight edge-sensitive interrupt lines and reports the most urgent one to a processor. Line 0 has the highest priority and line 7 the lowest. The processor talks to it over an 8-bit write/read bus with a single address bit, which selects between a control port (address 0) and a data port (address 1). Software starts a short setup sequence with a control write. The sequence sets the vector base, the cascade arrangement and whether end-of-interrupt happens automatically. After that, data writes load the mask, and control writes issue end-of-interrupt commands or choose which internal register a control-port read returns.

A rising edge on a line latches a request. The block raises its interrupt output when an unmasked request outranks everything currently in service. When the processor pulses the acknowledge input, the block answers on the following cycle with an 8-bit vector made of the programmed base and the index of the winning line, and it normally moves that line into service. Two copies can be joined into a 16-line controller. One copy is strapped as master, and the other is a slave that answers only when the master names it on the 3-bit cascade lines.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask is 0xFF, the request and in-service registers are zero, the interrupt output and the vector-valid output are low, control-port reads return the request register, and the block acts as a single, non-cascaded controller.
- R2: A control-port write with bit 4 set starts setup. It sets the mask to 0xFF, clears requests and in-service bits, selects the request register for reads and turns automatic EOI off. In that word, bit 0 = 1 announces a mode word, and bit 1 = 1 selects single mode (0 = cascade).
- R3: The first data-port write after setup start is the vector base. Only bits 7:3 are kept, and every vector is {base[7:3], index[2:0]}.
- R4: In cascade mode the next data write is the cascade word. If a mode word was announced, the data write after that is the mode word, whose bit 1 = 1 enables automatic EOI. With automatic EOI, an acknowledge sets no in-service bit.
- R5: Once setup is complete, a data-port write loads the mask (a 1 blocks that line), and a data-port read returns the mask.
- R6: A rising edge on line n sets request bit n, which stays set until line n is acknowledged.
- R7: The interrupt output is high exactly when some unmasked request has a lower index than every set in-service bit.
- R8: An acknowledge while the interrupt output is high clears the winning request bit and sets its in-service bit. In the following cycle the vector-valid output is high for one cycle, with the vector for that line.
- R9: An acknowledge while the interrupt output is low returns the vector with index 7 and changes no in-service bit.
- R10: Control write 0x20 clears the lowest-index set in-service bit. Control write 0x60|n clears in-service bit n.
- R11: Control write 0x0A selects the request register and 0x0B selects the in-service register for later control-port reads.
- R12: In cascade mode a master, when the winning line has its bit set in the cascade word, puts that line's index on the cascade output, takes it into service and suppresses its own vector. A slave acts on an acknowledge only when the cascade input equals bits 2:0 of its cascade word; otherwise the acknowledge has no effect.
- R13: When a new rising edge on line n arrives in the same cycle as the acknowledge of line n, request bit n stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 1 | 0 = control port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed port |
| irq_lines | input | 8 | Interrupt request lines, rising-edge sensitive |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge pulse from the processor |
| vec_out | output | 8 | Vector of the last acknowledge this block answered |
| vec_valid | output | 1 | High for one cycle when vec_out is new |
| strap_master | input | 1 | 1 = master, 0 = slave in cascade mode |
| casc_in | input | 3 | Slave identity selected by the master |
| casc_out | output | 3 | Index of the slave-attached line being acknowledged |

## Verification
An acknowledge clears a request bit, and a fresh rising edge sets one. Both can land on the same line in the same cycle. The bench provokes this by dropping a pending line, then raising it again on the very cycle it pulses acknowledge. It judges the result by the vector for that line, by the request register still showing the bit, and by the in-service register showing it too. The interrupt output must then stay low until an end-of-interrupt command, because the new request no longer outranks the service in progress.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NUM_LINES  = 8;
  localparam int unsigned LINE_IDX_W = $clog2(NUM_LINES);
  localparam int unsigned BUS_W      = 8;
  localparam int unsigned BASE_W     = BUS_W - LINE_IDX_W;

  typedef enum logic [1:0] {
    ST_READY,
    ST_BASE,
    ST_CASC,
    ST_MODE
  } setup_st_t;

  // command field (bits 7:5) of a control write with bits 4:3 clear
  localparam logic [2:0] CMD_EOI_ANY = 3'b001;
  localparam logic [2:0] CMD_EOI_LVL = 3'b011;

  function automatic logic [LINE_IDX_W-1:0] lowest_idx(input logic [NUM_LINES-1:0] v);
    logic [LINE_IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (v[i]) r = LINE_IDX_W'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/pic_cfg_ctrl.sv
module pic_cfg_ctrl
  import pic_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  addr,
  input  logic [BUS_W-1:0]      wdata,
  output logic [NUM_LINES-1:0]  mask_q,
  output logic [BASE_W-1:0]     base_q,
  output logic                  single_q,
  output logic                  aeoi_q,
  output logic [BUS_W-1:0]      casc_q,
  output logic                  rd_isr_q,
  output logic                  setup_start,
  output logic                  eoi_any,
  output logic                  eoi_lvl,
  output logic [LINE_IDX_W-1:0] eoi_idx
);
  setup_st_t               st_q, st_n;
  logic                    need_mode_q, need_mode_n;
  logic [NUM_LINES-1:0]    mask_n;
  logic [BASE_W-1:0]       base_n;
  logic                    single_n, aeoi_n, rd_isr_n;
  logic [BUS_W-1:0]        casc_n;
  logic                    ctl_wr, dat_wr, ready;

  assign ctl_wr      = wr_en && !addr;
  assign dat_wr      = wr_en && addr;
  assign ready       = (st_q == ST_READY);
  assign setup_start = ctl_wr && wdata[4];
  assign eoi_any     = ctl_wr && ready && !wdata[4] && !wdata[3] && (wdata[7:5] == CMD_EOI_ANY);
  assign eoi_lvl     = ctl_wr && ready && !wdata[4] && !wdata[3] && (wdata[7:5] == CMD_EOI_LVL);
  assign eoi_idx     = wdata[LINE_IDX_W-1:0];

  always_comb begin
    st_n        = st_q;
    need_mode_n = need_mode_q;
    mask_n      = mask_q;
    base_n      = base_q;
    single_n    = single_q;
    aeoi_n      = aeoi_q;
    casc_n      = casc_q;
    rd_isr_n    = rd_isr_q;
    if (setup_start) begin
      st_n        = ST_BASE;
      need_mode_n = wdata[0];
      single_n    = wdata[1];
      aeoi_n      = 1'b0;
      mask_n      = '1;
      rd_isr_n    = 1'b0;
    end else if (ctl_wr && ready && wdata[3]) begin
      if (wdata[1]) rd_isr_n = wdata[0];
    end else if (dat_wr) begin
      unique case (st_q)
        ST_READY: mask_n = wdata;
        ST_BASE: begin
          base_n = wdata[BUS_W-1:LINE_IDX_W];
          if (!single_q)       st_n = ST_CASC;
          else if (need_mode_q) st_n = ST_MODE;
          else                 st_n = ST_READY;
        end
        ST_CASC: begin
          casc_n = wdata;
          st_n   = need_mode_q ? ST_MODE : ST_READY;
        end
        ST_MODE: begin
          aeoi_n = wdata[1];
          st_n   = ST_READY;
        end
        default: st_n = ST_READY;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_READY;
      need_mode_q <= 1'b0;
      mask_q      <= '1;
      base_q      <= '0;
      single_q    <= 1'b1;
      aeoi_q      <= 1'b0;
      casc_q      <= '0;
      rd_isr_q    <= 1'b0;
    end else begin
      st_q        <= st_n;
      need_mode_q <= need_mode_n;
      mask_q      <= mask_n;
      base_q      <= base_n;
      single_q    <= single_n;
      aeoi_q      <= aeoi_n;
      casc_q      <= casc_n;
      rd_isr_q    <= rd_isr_n;
    end
  end

  assert_setup_masks_R2: assert property (@(posedge clk) disable iff (!rst_n)
    setup_start |=> (mask_q == '1) && !rd_isr_q && !aeoi_q && (st_q == ST_BASE));

  assert_mask_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && ready |=> mask_q == $past(wdata));

  assert_base_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr && (st_q == ST_BASE) |=> base_q == $past(wdata[BUS_W-1:LINE_IDX_W]));
endmodule

// File: rtl/pic_req_track.sv
module pic_req_track
  import pic_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  lines,
  input  logic                  clr_all,
  input  logic                  take,
  input  logic [LINE_IDX_W-1:0] take_idx,
  input  logic                  set_isr,
  input  logic                  eoi_any,
  input  logic                  eoi_lvl,
  input  logic [LINE_IDX_W-1:0] eoi_idx,
  output logic [NUM_LINES-1:0]  irr_q,
  output logic [NUM_LINES-1:0]  isr_q
);
  logic [NUM_LINES-1:0] prev_q, rise, irr_n, isr_n;

  assign rise = lines & ~prev_q;

  always_comb begin
    irr_n = irr_q;
    if (take) irr_n[take_idx] = 1'b0;
    irr_n = irr_n | rise;
    if (clr_all) irr_n = '0;
  end

  always_comb begin
    isr_n = isr_q;
    if (eoi_any) isr_n[lowest_idx(isr_q)] = 1'b0;
    if (eoi_lvl) isr_n[eoi_idx] = 1'b0;
    if (take && set_isr) isr_n[take_idx] = 1'b1;
    if (clr_all) isr_n = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
      isr_q  <= '0;
    end else begin
      prev_q <= lines;
      irr_q  <= irr_n;
      isr_q  <= isr_n;
    end
  end

  assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_all && (rise != '0) |=> (irr_q & $past(rise)) == $past(rise));

  assert_lvl_eoi_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_lvl && !take && !clr_all |=> !isr_q[$past(eoi_idx)]);

  assert_isr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && set_isr && !clr_all |=> isr_q[$past(take_idx)]);
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_pkg::*;
(
  input  logic [NUM_LINES-1:0]  irr,
  input  logic [NUM_LINES-1:0]  mask,
  input  logic [NUM_LINES-1:0]  isr,
  output logic [LINE_IDX_W-1:0] win_idx,
  output logic                  req
);
  logic [NUM_LINES-1:0]  pend;
  logic [LINE_IDX_W-1:0] busy_idx;

  assign pend     = irr & ~mask;
  assign win_idx  = lowest_idx(pend);
  assign busy_idx = lowest_idx(isr);
  assign req      = (pend != '0) && ((isr == '0) || (win_idx < busy_idx));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import pic_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_addr,
  input  logic [BUS_W-1:0]      bus_wdata,
  output logic [BUS_W-1:0]      bus_rdata,
  input  logic [NUM_LINES-1:0]  irq_lines,
  output logic                  int_req,
  input  logic                  int_ack,
  output logic [BUS_W-1:0]      vec_out,
  output logic                  vec_valid,
  input  logic                  strap_master,
  input  logic [LINE_IDX_W-1:0] casc_in,
  output logic [LINE_IDX_W-1:0] casc_out
);
  logic [NUM_LINES-1:0]  mask_q, irr_q, isr_q;
  logic [BASE_W-1:0]     base_q;
  logic                  single_q, aeoi_q, rd_isr_q;
  logic [BUS_W-1:0]      casc_q;
  logic                  setup_start, eoi_any, eoi_lvl;
  logic [LINE_IDX_W-1:0] eoi_idx, win_idx, ack_idx;
  logic                  slave_hit, ack_here, take, to_slave, answer;
  logic [BUS_W-1:0]      vec_n;
  logic                  vec_valid_n;

  pic_cfg_ctrl u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .mask_q(mask_q), .base_q(base_q), .single_q(single_q), .aeoi_q(aeoi_q),
    .casc_q(casc_q), .rd_isr_q(rd_isr_q), .setup_start(setup_start),
    .eoi_any(eoi_any), .eoi_lvl(eoi_lvl), .eoi_idx(eoi_idx)
  );

  pic_resolver u_res (
    .irr(irr_q), .mask(mask_q), .isr(isr_q), .win_idx(win_idx), .req(int_req)
  );

  pic_req_track u_trk (
    .clk(clk), .rst_n(rst_n), .lines(irq_lines), .clr_all(setup_start),
    .take(take), .take_idx(win_idx), .set_isr(!aeoi_q),
    .eoi_any(eoi_any), .eoi_lvl(eoi_lvl), .eoi_idx(eoi_idx),
    .irr_q(irr_q), .isr_q(isr_q)
  );

  assign slave_hit = (casc_in == casc_q[LINE_IDX_W-1:0]);
  assign ack_here  = int_ack && (single_q || strap_master || slave_hit);
  assign take      = ack_here && int_req;
  assign ack_idx   = int_req ? win_idx : LINE_IDX_W'(NUM_LINES - 1);
  assign to_slave  = !single_q && strap_master && int_req && casc_q[win_idx];
  assign answer    = ack_here && !to_slave;
  assign casc_out  = to_slave ? win_idx : '0;
  assign bus_rdata = bus_addr ? mask_q : (rd_isr_q ? isr_q : irr_q);

  always_comb begin
    vec_valid_n = answer;
    vec_n       = answer ? {base_q, ack_idx} : vec_out;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_out   <= '0;
      vec_valid <= 1'b0;
    end else begin
      vec_out   <= vec_n;
      vec_valid <= vec_valid_n;
    end
  end

  assert_req_has_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (irr_q & ~mask_q) != '0);

  assert_vector_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    answer && int_req |=> vec_valid && (vec_out == {$past(base_q), $past(win_idx)}));

  assert_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_here && !int_req && !setup_start && !eoi_any && !eoi_lvl
    |=> vec_valid && (vec_out[LINE_IDX_W-1:0] == '1) && (isr_q == $past(isr_q)));

  assert_slave_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && !single_q && !strap_master && !slave_hit |=> !vec_valid);

  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(int_ack));
endmodule

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] irq_lines = 8'h00;
  logic       int_req;
  logic       int_ack = 1'b0;
  logic [7:0] vec_out;
  logic       vec_valid;
  logic       strap_master = 1'b1;
  logic [2:0] casc_in = 3'd0;
  logic [2:0] casc_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .int_req(int_req), .int_ack(int_ack), .vec_out(vec_out), .vec_valid(vec_valid),
    .strap_master(strap_master), .casc_in(casc_in), .casc_out(casc_out)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_lines(input logic [7:0] v);
    @(negedge clk);
    irq_lines = v;
    @(negedge clk);
    #1;
  endtask

  task automatic ack(output logic vv, output logic [7:0] vo);
    @(negedge clk);
    int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    #1 vv = vec_valid; vo = vec_out;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(1'b1, d); check("R1 mask", d, 8'hFF);
    rd(1'b0, d); check("R1 irr", d, 8'h00);
    check("R1 int_req", {7'd0, int_req}, 8'h00);
    check("R1 vec_valid", {7'd0, vec_valid}, 8'h00);
  endtask

  task automatic t_setup_mask;
    logic [7:0] d;
    wr(1'b0, 8'h12);
    wr(1'b1, 8'h47);
    rd(1'b1, d); check("R2 mask after setup", d, 8'hFF);
    wr(1'b1, 8'hA5);
    rd(1'b1, d); check("R5 mask readback", d, 8'hA5);
    wr(1'b1, 8'h00);
    rd(1'b1, d); check("R5 mask cleared", d, 8'h00);
  endtask

  task automatic t_priority;
    logic [7:0] d, vo;
    logic vv;
    set_lines(8'h20);
    check("R6 int_req after edge", {7'd0, int_req}, 8'h01);
    rd(1'b0, d); check("R6 R11 irr", d, 8'h20);
    ack(vv, vo);
    check("R8 valid", {7'd0, vv}, 8'h01);
    check("R3 R8 vector line 5", vo, 8'h45);
    rd(1'b0, d); check("R8 irr cleared", d, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R11 isr", d, 8'h20);
    set_lines(8'h60);
    check("R7 lower priority blocked", {7'd0, int_req}, 8'h00);
    set_lines(8'h62);
    check("R7 higher priority nests", {7'd0, int_req}, 8'h01);
    ack(vv, vo);
    check("R8 vector line 1", vo, 8'h41);
    rd(1'b0, d); check("R8 nested isr", d, 8'h22);
    wr(1'b0, 8'h20);
    rd(1'b0, d); check("R10 nonspecific eoi", d, 8'h20);
    check("R7 still blocked", {7'd0, int_req}, 8'h00);
    wr(1'b0, 8'h65);
    rd(1'b0, d); check("R10 specific eoi", d, 8'h00);
    check("R7 line 6 now wins", {7'd0, int_req}, 8'h01);
    ack(vv, vo);
    check("R8 vector line 6", vo, 8'h46);
    wr(1'b0, 8'h66);
    wr(1'b0, 8'h0A);
    set_lines(8'h00);
  endtask

  task automatic t_spurious;
    logic [7:0] d, vo;
    logic vv;
    set_lines(8'h08);
    wr(1'b1, 8'h08);
    check("R7 masked no req", {7'd0, int_req}, 8'h00);
    ack(vv, vo);
    check("R9 valid", {7'd0, vv}, 8'h01);
    check("R9 spurious vector", vo, 8'h47);
    rd(1'b0, d); check("R9 irr kept", d, 8'h08);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R9 isr untouched", d, 8'h00);
    wr(1'b1, 8'h00);
    ack(vv, vo);
    check("R8 vector line 3", vo, 8'h43);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0A);
    set_lines(8'h00);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d, vo;
    logic vv;
    set_lines(8'h10);
    set_lines(8'h00);
    @(negedge clk);
    irq_lines = 8'h10; int_ack = 1'b1;
    @(negedge clk);
    int_ack = 1'b0;
    #1 vv = vec_valid; vo = vec_out;
    check("R13 vector", vo, 8'h44);
    rd(1'b0, d); check("R13 irr stays set", d, 8'h10);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R13 isr set", d, 8'h10);
    check("R13 R7 no req same line", {7'd0, int_req}, 8'h00);
    wr(1'b0, 8'h20);
    check("R13 req after eoi", {7'd0, int_req}, 8'h01);
    ack(vv, vo);
    check("R13 second vector", vo, 8'h44);
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0A);
    set_lines(8'h00);
  endtask

  task automatic t_cascade_master;
    logic [7:0] d, vo;
    logic vv;
    strap_master = 1'b1;
    wr(1'b0, 8'h11); wr(1'b1, 8'h20); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    wr(1'b1, 8'h00);
    set_lines(8'h04);
    check("R12 casc_out", {5'd0, casc_out}, 8'h02);
    ack(vv, vo);
    check("R12 master silent", {7'd0, vv}, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R12 master isr", d, 8'h04);
    set_lines(8'h05);
    check("R12 casc_out idle line 0", {5'd0, casc_out}, 8'h00);
    ack(vv, vo);
    check("R12 master own vector", vo, 8'h20);
    check("R12 master own valid", {7'd0, vv}, 8'h01);
    wr(1'b0, 8'h20); wr(1'b0, 8'h20);
    rd(1'b0, d); check("R10 isr empty", d, 8'h00);
    set_lines(8'h00);
  endtask

  task automatic t_cascade_slave;
    logic [7:0] d, vo;
    logic vv;
    strap_master = 1'b0;
    wr(1'b0, 8'h11); wr(1'b1, 8'h28); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
    wr(1'b1, 8'h00);
    set_lines(8'h08);
    casc_in = 3'd5;
    ack(vv, vo);
    check("R12 slave other id ignored", {7'd0, vv}, 8'h00);
    rd(1'b0, d); check("R12 slave irr kept", d, 8'h08);
    casc_in = 3'd2;
    ack(vv, vo);
    check("R12 slave answers", {7'd0, vv}, 8'h01);
    check("R3 R12 slave vector", vo, 8'h2B);
    wr(1'b0, 8'h63);
    set_lines(8'h01);
    strap_master = 1'b1;
  endtask

  task automatic t_auto_eoi;
    logic [7:0] d, vo;
    logic vv;
    wr(1'b0, 8'h13);
    rd(1'b1, d); check("R2 setup masks", d, 8'hFF);
    rd(1'b0, d); check("R2 setup clears irr", d, 8'h00);
    wr(1'b1, 8'h40); wr(1'b1, 8'h03);
    wr(1'b1, 8'h00);
    set_lines(8'h00);
    set_lines(8'h04);
    ack(vv, vo);
    check("R4 aeoi vector", vo, 8'h42);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R4 aeoi no isr", d, 8'h00);
    check("R4 no req", {7'd0, int_req}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_setup_mask();
    t_priority();
    t_spurious();
    t_same_cycle();
    t_cascade_master();
    t_cascade_slave();
    t_auto_eoi();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule